// File: doc/BRIEF.md
# RGB LED Matrix Scan Controller

This block refreshes a chain of RGB LED matrix panels that have no grey-scale logic of their own. Sixteen RGB output channels (48 data lines) are shifted in parallel. All panels share one shift clock, a latch strobe, an active-low display enable and a binary row-select bus. Pixel data is read one column at a time from a frame memory through a synchronous read port with one cycle of latency. Each read returns 48 bytes, which is one red, green and blue byte for each of the sixteen channels.

Grey levels come from repeating every row many times while a brightness threshold steps down. On each pass a data line is lit only if its colour byte is above the current threshold. A byte with a high value is therefore shown on more passes, and appears brighter.

The host controls the block through two mailbox inputs: a frame base address and a row length in bytes. The block reads these inputs only between frames, so a new frame is taken up without tearing. Writing address zero pauses the block. Writing address 0xFF stops it for good and raises a completion flag. A status output shows that the block has come out of reset and is running.

Top module: `mxs_matrix_scan`

## Requirements
- R1: In a fetched word, byte k sits at bits [8k+7:8k]. Byte k = 3c+j drives `pix_data[3c+j]`, where c is the channel (0 to 15) and j is the colour: 0 red, 1 green, 2 blue.
- R2: A data line is driven high only when its colour byte is strictly greater than the current threshold. Otherwise it is driven low.
- R3: Each row is shown in 16 passes. The thresholds are 256, 240, ... 16, in that order. Each pass shifts length/48 columns before it latches. The length must be a multiple of 48.
- R4: When the row changes, `oe_n` is high in the cycle where `row_sel` takes the new binary row index.
- R5: `latch` stays low while columns are shifted. It goes high for exactly one cycle after the last column, and `oe_n` goes low in that same cycle.
- R6: Each column produces exactly one rising edge of `sclk`. The data lines are updated while `sclk` is low and are stable at the rising edge.
- R7: A frame covers rows 0 to 7. The mailbox is sampled only after row 7 finishes its last pass. Mailbox changes made in the middle of a frame take effect at the next frame.
- R8: A mailbox address of 0 pauses the block. While paused, no memory reads occur, no latch pulses occur, `oe_n` is high and all data lines are low.
- R9: A mailbox address of 0xFF makes `done_irq` rise and stay high. From then on there are no reads, `oe_n` stays high and the data lines stay low.
- R10: `status_running` is 0 during reset and is 1 from the first clock after reset, and stays 1.
- R11: Column m of row r is read from address base + r*length + 48*m.
- R12: With a row length of 0, every pass only pulses `latch`. No memory read is made, and each frame still produces 128 latch pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mbox_addr | input | ADDR_W | Frame base address; 0 pauses, 0xFF stops |
| mbox_len | input | LEN_W | Row length in bytes |
| status_running | output | 1 | High once the block has started |
| done_irq | output | 1 | Completion flag after a stop command |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address of a column |
| mem_rd_data | input | NUM_CH*3*8 | Column word, valid one cycle after the strobe |
| pix_data | output | NUM_CH*3 | Panel data lines |
| sclk | output | 1 | Shift clock, one rising edge per column |
| latch | output | 1 | Row latch strobe |
| oe_n | output | 1 | Active-low display enable |
| row_sel | output | ROW_W | Binary row address |

## Verification
The memory model returns bytes from an odd-multiplier formula over address and byte index. Across one frame this covers every byte value, including 0, 255 and bytes equal to a threshold. A strict-versus-inclusive comparison and a swapped byte lane therefore give different vectors. Frames of one, two and three columns show whether the end-of-row test and the row stride use the configured length. A zero-length frame shows whether empty rows still latch without reading. The mailbox is changed in the middle of a frame, which separates adoption at the frame boundary from adoption mid-frame. Pause and stop commands are issued from a running state, so the bench can show that output activity actually ceases.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
   typedef enum logic [2:0] {
      ST_POLL, ST_ROW, ST_PASS, ST_FETCH, ST_LOAD, ST_EDGE, ST_LATCH, ST_HALT
   } mxs_state_e;
endpackage

// File: rtl/mxs_slicer.sv
module mxs_slicer #(
   parameter int NUM_CH = 16,
   parameter int BYTE_W = 8,
   localparam int LINES = NUM_CH * 3,
   localparam int THR_W = BYTE_W + 1
) (
   input  logic [LINES*BYTE_W-1:0] word,
   input  logic [THR_W-1:0]        thr,
   output logic [LINES-1:0]        bits
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign bits[i] = {1'b0, word[i*BYTE_W +: BYTE_W]} > thr;
   end
endmodule

// File: rtl/mxs_pass_ctr.sv
module mxs_pass_ctr #(
   parameter int BYTE_W = 8,
   parameter int STEP   = 16,
   localparam int THR_W = BYTE_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             dec,
   output logic [THR_W-1:0] thr,
   output logic             last
);
   localparam logic [THR_W-1:0] THR_INIT = THR_W'(1) << BYTE_W;
   localparam logic [THR_W-1:0] THR_STEP = THR_W'(STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    thr <= THR_INIT;
      else if (load) thr <= THR_INIT;
      else if (dec)  thr <= thr - THR_STEP;
   end

   assign last = (thr <= THR_STEP);
endmodule

// File: rtl/mxs_scan_fsm.sv
module mxs_scan_fsm
   import mxs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int LEN_W     = 16,
   parameter int ROWS      = 8,
   parameter int COL_BYTES = 48,
   parameter int STOP_CODE = 255,
   localparam int ROW_W    = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] mbox_addr,
   input  logic [LEN_W-1:0]  mbox_len,
   input  logic              thr_last,
   output logic              thr_load,
   output logic              thr_dec,
   output logic              ld_data,
   output logic              clr_data,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   output logic              sclk,
   output logic              latch,
   output logic              oe_n,
   output logic [ROW_W-1:0]  row_sel,
   output logic              running,
   output logic              done
);
   localparam logic [LEN_W-1:0]  COL_STEP = LEN_W'(COL_BYTES);
   localparam logic [ROW_W-1:0]  ROW_LAST = ROW_W'(ROWS - 1);
   localparam logic [ADDR_W-1:0] STOP_VAL = ADDR_W'(STOP_CODE);

   mxs_state_e        state;
   logic [ROW_W-1:0]  row_q;
   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  off_q;
   logic [LEN_W-1:0]  off_nx;

   assign off_nx = off_q + COL_STEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_POLL;
         row_q   <= '0;
         base_q  <= '0;
         len_q   <= '0;
         off_q   <= '0;
         sclk    <= 1'b0;
         latch   <= 1'b0;
         oe_n    <= 1'b1;
         row_sel <= '0;
         running <= 1'b0;
         done    <= 1'b0;
      end else begin
         running <= 1'b1;
         latch   <= 1'b0;
         case (state)
            ST_POLL: begin
               oe_n <= 1'b1;
               if (mbox_addr == STOP_VAL) begin
                  done  <= 1'b1;
                  state <= ST_HALT;
               end else if (mbox_addr != '0) begin
                  base_q <= mbox_addr;
                  len_q  <= mbox_len;
                  row_q  <= '0;
                  state  <= ST_ROW;
               end
            end
            ST_ROW: begin
               oe_n    <= 1'b1;
               row_sel <= row_q;
               state   <= ST_PASS;
            end
            ST_PASS: begin
               off_q <= '0;
               state <= (len_q == '0) ? ST_LATCH : ST_FETCH;
            end
            ST_FETCH: state <= ST_LOAD;
            ST_LOAD: begin
               sclk  <= 1'b0;
               state <= ST_EDGE;
            end
            ST_EDGE: begin
               sclk  <= 1'b1;
               off_q <= off_nx;
               state <= (off_nx >= len_q) ? ST_LATCH : ST_FETCH;
            end
            ST_LATCH: begin
               latch <= 1'b1;
               oe_n  <= 1'b0;
               if (!thr_last) begin
                  state <= ST_PASS;
               end else begin
                  base_q <= base_q + ADDR_W'(len_q);
                  if (row_q == ROW_LAST) begin
                     state <= ST_POLL;
                  end else begin
                     row_q <= row_q + 1'b1;
                     state <= ST_ROW;
                  end
               end
            end
            ST_HALT: oe_n <= 1'b1;
            default: state <= ST_POLL;
         endcase
      end
   end

   assign thr_load    = (state == ST_ROW);
   assign thr_dec     = (state == ST_LATCH);
   assign ld_data     = (state == ST_LOAD);
   assign clr_data    = (state == ST_POLL) || (state == ST_HALT);
   assign mem_rd_en   = (state == ST_FETCH);
   assign mem_rd_addr = base_q + ADDR_W'(off_q);
endmodule

// File: rtl/mxs_matrix_scan.sv
module mxs_matrix_scan #(
   parameter int NUM_CH    = 16,
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 16,
   parameter int LEN_W     = 16,
   parameter int ROWS      = 8,
   parameter int STEP      = 16,
   parameter int STOP_CODE = 255,
   localparam int LINES    = NUM_CH * 3,
   localparam int WORD_W   = LINES * BYTE_W,
   localparam int ROW_W    = $clog2(ROWS),
   localparam int THR_W    = BYTE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] mbox_addr,
   input  logic [LEN_W-1:0]  mbox_len,
   output logic              status_running,
   output logic              done_irq,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [WORD_W-1:0] mem_rd_data,
   output logic [LINES-1:0]  pix_data,
   output logic              sclk,
   output logic              latch,
   output logic              oe_n,
   output logic [ROW_W-1:0]  row_sel
);
   initial begin
      assert (ROWS >= 2) else $error("ROWS must be at least 2");
      assert (STEP > 0 && ((1 << BYTE_W) % STEP) == 0)
         else $error("STEP must divide the threshold range");
      assert (LEN_W <= ADDR_W) else $error("LEN_W wider than ADDR_W");
   end

   logic [THR_W-1:0] thr;
   logic             thr_last, thr_load, thr_dec, ld_data, clr_data;
   logic [LINES-1:0] slice;

   mxs_scan_fsm #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROWS(ROWS),
      .COL_BYTES(LINES), .STOP_CODE(STOP_CODE)
   ) i_fsm (
      .clk(clk), .rst_n(rst_n), .mbox_addr(mbox_addr), .mbox_len(mbox_len),
      .thr_last(thr_last), .thr_load(thr_load), .thr_dec(thr_dec),
      .ld_data(ld_data), .clr_data(clr_data), .mem_rd_en(mem_rd_en),
      .mem_rd_addr(mem_rd_addr), .sclk(sclk), .latch(latch), .oe_n(oe_n),
      .row_sel(row_sel), .running(status_running), .done(done_irq)
   );

   mxs_pass_ctr #(.BYTE_W(BYTE_W), .STEP(STEP)) i_pass (
      .clk(clk), .rst_n(rst_n), .load(thr_load), .dec(thr_dec),
      .thr(thr), .last(thr_last)
   );

   mxs_slicer #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) i_slice (
      .word(mem_rd_data), .thr(thr), .bits(slice)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pix_data <= '0;
      else if (clr_data) pix_data <= '0;
      else if (ld_data)  pix_data <= slice;
   end
endmodule

// File: rtl/mxs_scan_chk.sv
module mxs_scan_chk #(
   parameter int DW = 48,
   parameter int RW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_rd_en,
   input logic [DW-1:0] pix_data,
   input logic          sclk,
   input logic          latch,
   input logic          oe_n,
   input logic [RW-1:0] row_sel,
   input logic          status_running,
   input logic          done_irq
);
   assert_row_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_sel) |-> oe_n);

   assert_latch_lit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      latch |-> !oe_n);

   assert_latch_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> !latch);

   assert_edge_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(pix_data));

   assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> (!mem_rd_en && oe_n && pix_data == '0));

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> done_irq);

   assert_run_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      status_running |=> status_running);
endmodule

bind mxs_matrix_scan mxs_scan_chk #(.DW(LINES), .RW(ROW_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .pix_data(pix_data),
   .sclk(sclk), .latch(latch), .oe_n(oe_n), .row_sel(row_sel),
   .status_running(status_running), .done_irq(done_irq)
);

// File: tb/test_mxs_matrix_scan.sv
module test_mxs_matrix_scan;
   localparam int NCH = 16, BW = 8, AW = 16, LW = 16, ROWS = 8, COLB = 48;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [AW-1:0]        mb_addr = '0;
   logic [LW-1:0]        mb_len = 16'd96;
   logic                 running, done_irq, rd_en, sclk, latch, oe_n;
   logic [AW-1:0]        rd_addr;
   logic [COLB*BW-1:0]   rdata = '0;
   logic [COLB-1:0]      pix;
   logic [2:0]           row_sel;

   mxs_matrix_scan i_mxs_matrix_scan (
      .clk(clk), .rst_n(rst_n), .mbox_addr(mb_addr), .mbox_len(mb_len),
      .status_running(running), .done_irq(done_irq), .mem_rd_en(rd_en),
      .mem_rd_addr(rd_addr), .mem_rd_data(rdata), .pix_data(pix),
      .sclk(sclk), .latch(latch), .oe_n(oe_n), .row_sel(row_sel)
   );

   function automatic logic [7:0] byte_at(input int a, input int k);
      return 8'(((a + k) * 29) + 5);
   endfunction

   always @(posedge clk)
      if (rd_en)
         for (int k = 0; k < COLB; k++) rdata[k*8 +: 8] <= byte_at(int'(rd_addr), k);

   int checks = 0, bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor model
   int m_row = 0, m_pass = 0, m_col = 0, m_base = 0, m_len = 0;
   int frames = 0, fetches = 0, latches = 0, last_addr = 0;
   bit need_adopt = 1, p_sclk = 0, p_latch = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk && !p_sclk) begin
            logic [COLB-1:0] ev;
            int thr;
            thr = 256 - 16 * m_pass;
            for (int k = 0; k < COLB; k++) ev[k] = int'(byte_at(last_addr, k)) > thr;
            check(pix == ev, "R1/R2", "column data", longint'(pix), longint'(ev));
            m_col++;
         end
         if (latch && !p_latch) begin
            if (need_adopt) begin m_base = int'(mb_addr); m_len = int'(mb_len); need_adopt = 0; end
            latches++;
            check(m_col == m_len / COLB, "R3", "columns per pass", m_col, m_len / COLB);
            check(int'(row_sel) == m_row, "R4", "row select", row_sel, m_row);
            check(oe_n == 1'b0, "R5", "display on at latch", oe_n, 0);
            m_col = 0;
            m_pass++;
            if (m_pass == 16) begin
               m_pass = 0;
               m_row++;
               if (m_row == ROWS) begin m_row = 0; need_adopt = 1; frames++; end
            end
         end
         if (rd_en) begin
            int ea;
            if (need_adopt) begin m_base = int'(mb_addr); m_len = int'(mb_len); need_adopt = 0; end
            ea = (m_base + m_row * m_len + m_col * COLB) & 16'hFFFF;
            check(int'(rd_addr) == ea, "R11", "read address", rd_addr, ea);
            check(m_len != 0, "R12", "no read at zero length", m_len, 1);
            last_addr = int'(rd_addr);
            fetches++;
         end
      end
      p_sclk  = sclk;
      p_latch = latch;
   end

   task automatic finish_run;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   task automatic wait_row(input int r);
      while (m_row != r) @(negedge clk);
   endtask

   initial begin
      int f0, n0, l0;
      repeat (5) @(negedge clk);
      check(oe_n && !latch && !sclk && pix == '0 && !done_irq && !rd_en,
            "R10", "reset outputs", {oe_n, latch, sclk, done_irq, rd_en}, 5'b10000);
      check(running == 1'b0, "R10", "running in reset", running, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(running == 1'b1, "R10", "running after reset", running, 1);

      // paused from the start
      repeat (50) @(negedge clk);
      check(fetches == 0 && latches == 0, "R8", "activity while paused", fetches + latches, 0);
      check(oe_n == 1'b1 && pix == '0, "R8", "outputs while paused", {oe_n, pix}, 49'h1_0000_0000_0000);

      // two-column frames, then mailbox change mid-frame
      mb_addr = 16'h0100; mb_len = 16'd96;
      wait (frames == 1);
      wait_row(3);
      mb_addr = 16'h2000; mb_len = 16'd144;   // R7: must not apply before frame end
      wait (frames == 3);

      // zero-length frame
      wait_row(2);
      mb_addr = 16'h3000; mb_len = 16'd0;
      f0 = frames + 1;
      wait (frames == f0);
      n0 = fetches; l0 = latches;
      wait (frames == f0 + 1);
      check(fetches == n0, "R12", "reads in empty frame", fetches - n0, 0);
      check(latches - l0 == 128, "R12", "latches in empty frame", latches - l0, 128);

      // single-column frame
      wait_row(3);
      mb_addr = 16'h0400; mb_len = 16'd48;
      wait (frames == f0 + 3);

      // pause from a running state
      wait_row(4);
      mb_addr = 16'h0000;
      wait (frames == f0 + 4);
      repeat (5) @(negedge clk);
      n0 = fetches; l0 = latches;
      repeat (60) @(negedge clk);
      check(fetches == n0 && latches == l0, "R8", "paused mid-run", fetches - n0 + latches - l0, 0);
      check(oe_n == 1'b1 && pix == '0, "R8", "paused outputs", oe_n, 1);

      // resume, then stop
      mb_addr = 16'h0800; mb_len = 16'd96;
      wait (frames == f0 + 5);
      wait_row(4);
      check(done_irq == 1'b0, "R9", "no done while running", done_irq, 0);
      mb_addr = 16'h00FF;
      wait (frames == f0 + 6);
      repeat (5) @(negedge clk);
      check(done_irq == 1'b1, "R9", "done after stop", done_irq, 1);
      n0 = fetches; l0 = latches;
      mb_addr = 16'h0100;
      repeat (80) @(negedge clk);
      check(fetches == n0 && latches == l0, "R9", "quiet after stop", fetches - n0 + latches - l0, 0);
      check(oe_n && pix == '0 && done_irq, "R9", "stopped outputs", {oe_n, done_irq}, 2'b11);
      check(frames == f0 + 6, "R7", "frame count", frames, f0 + 6);
      finish_run();
   end
endmodule